// File: doc/BRIEF.md
# Product-Term Cluster Steering Network

This block sits between a product-term array and a row of macrocells. It takes 64 product-term values, grouped into 16 clusters of four consecutive terms. It forms one sum-of-products result for each of 16 macrocells. Each macrocell sees a sliding window of up to four neighbouring clusters, so one cell can combine as many as sixteen terms. A per-cell 4-bit mask picks which clusters in the window take part. Windows overlap between neighbouring cells. Each cluster is meant to belong to one cell at most.

A configuration checker runs next to the steering logic and raises two flags:
- One flag reports a cluster that two or more cells claim.
- The other flag reports a mask bit that points outside the cell's window.

Out-of-window bits never reach the sum logic. The sums and both flags are registered, so they appear one clock after the inputs that produce them.

Top module: `ptClusterSteer`

## Requirements
- R1: While `rstN` is low, `sumOut`, `overlapErr` and `windowErr` are all 0.
- R2: Cluster c is active when any of the product terms `termsIn[4c]` through `termsIn[4c+3]` is 1.
- R3: Bit `selCfg[4m+k]` of cell m addresses cluster m-1+k. The position is inside the window only when m-1+k lies in 0..15. Cell 0 therefore reaches clusters 0..2 through k=1..3. Cell 14 reaches 13..15 through k=0..2. Cell 15 reaches 14..15 through k=0..1.
- R4: One clock after the inputs, `sumOut[m]` equals the OR of the active clusters that cell m selects at in-window positions.
- R5: A cell whose in-window mask bits are all 0 outputs 0.
- R6: A mask bit at an out-of-window position has no effect on any `sumOut` bit.
- R7: `windowErr` is 1 one clock after any out-of-window mask bit is 1, and 0 otherwise.
- R8: `overlapErr` is 1 one clock after any cluster is selected at in-window positions by two or more cells, and 0 otherwise. Out-of-window bits never count as claims.
- R9: A configuration with every cluster owned by at most one cell and no out-of-window bits produces both flags at 0.
- R10: A cell may select all four clusters of its window at once, so it can draw on up to 16 terms. Any one of those terms being 1 sets its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| termsIn | input | 64 | Product-term values; cluster c is bits 4c+3..4c |
| selCfg | input | 64 | Cluster-select masks; cell m uses bits 4m+3..4m, where bit k addresses cluster m-1+k |
| sumOut | output | 16 | Registered sum-of-products result for each cell |
| overlapErr | output | 1 | Registered flag: some cluster is claimed by more than one cell |
| windowErr | output | 1 | Registered flag: some mask bit lies outside its cell's window |

## Verification
The assertions check four properties on every clock:
- A cell with no granted cluster stays at 0.
- All-zero terms give all-zero sums.
- Every cluster has at most one claimant whenever the checker reports no overlap.
- Any out-of-window bit is flagged and an empty configuration is never flagged.

The exact OR composition depends on which cluster feeds which cell and where the windows are cut off at both ends. Only the bench scenarios can show this. They sweep every mask of every cell against single-term stimuli and compare against an arithmetic model. The same holds for overlap detection across neighbouring cells and for the claim that stray bits leave the sums untouched.

// File: rtl/ptAllocPkg.sv
package ptAllocPkg;
  // Number of clusters; the cell count equals it.
  localparam int CLUSTERS = 16;
  // Window width in clusters.
  localparam int WIN = 4;
  // How far below its own index a cell's window begins.
  localparam int WIN_LEAD = 1;
  // Default terms per cluster.
  localparam int TERMS_PER = 4;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic [CLUSTERS*WIN-1:0] grant;       // masked in-window selects
    logic                    overlapNow;  // combinational overlap of current config
  } steerCtl_t;
endpackage

// File: rtl/ptSteerCtl.sv
module ptSteerCtl
  import ptAllocPkg::*;
#(
  parameter int NCL  = ptAllocPkg::CLUSTERS,
  parameter int NWIN = ptAllocPkg::WIN,
  parameter int LEAD = ptAllocPkg::WIN_LEAD
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCL*NWIN-1:0]  selCfg,
  output steerCtl_t            ctl,
  output logic                 overlapErr,
  output logic                 windowErr
);
  localparam int NBITS = NCL * NWIN;

  // Marks mask positions whose cluster index falls off either end.
  function automatic logic [NBITS-1:0] strayMaskFn();
    logic [NBITS-1:0] r;
    r = '0;
    for (int m = 0; m < NCL; m++) begin
      for (int k = 0; k < NWIN; k++) begin
        if ((m - LEAD + k) < 0 || (m - LEAD + k) >= NCL) r[m*NWIN+k] = 1'b1;
      end
    end
    return r;
  endfunction

  localparam logic [NBITS-1:0] STRAY_MASK = strayMaskFn();

  logic [NBITS-1:0] grantVec;
  logic [NBITS-1:0] strayVec;
  logic [NCL-1:0]   overlapVec;

  generate
    for (genvar m = 0; m < NCL; m++) begin : g_cell
      for (genvar k = 0; k < NWIN; k++) begin : g_pos
        localparam int CL = m - LEAD + k;
        if (CL >= 0 && CL < NCL) begin : g_in
          assign grantVec[m*NWIN+k] = selCfg[m*NWIN+k];
          assign strayVec[m*NWIN+k] = 1'b0;
        end else begin : g_out
          assign grantVec[m*NWIN+k] = 1'b0;
          assign strayVec[m*NWIN+k] = selCfg[m*NWIN+k];
        end
      end
    end
  endgenerate

  // Count the claimants of every cluster.
  always_comb begin
    for (int c = 0; c < NCL; c++) begin
      automatic int cnt = 0;
      for (int k = 0; k < NWIN; k++) begin
        if ((c + LEAD - k) >= 0 && (c + LEAD - k) < NCL)
          cnt += int'(grantVec[(c + LEAD - k)*NWIN + k]);
      end
      overlapVec[c] = (cnt > 1);
    end
  end

  assign ctl.grant      = grantVec;
  assign ctl.overlapNow = |overlapVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overlapErr <= 1'b0;
      windowErr  <= 1'b0;
    end else begin
      overlapErr <= |overlapVec;
      windowErr  <= |strayVec;
    end
  end

  // R7
  stray_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((selCfg & STRAY_MASK) != '0) |=> windowErr);

  // R9
  empty_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selCfg == '0) |=> (!overlapErr && !windowErr));
endmodule

// File: rtl/ptSteerDp.sv
module ptSteerDp
  import ptAllocPkg::*;
#(
  parameter int NCL  = ptAllocPkg::CLUSTERS,
  parameter int NWIN = ptAllocPkg::WIN,
  parameter int LEAD = ptAllocPkg::WIN_LEAD,
  parameter int TPC  = ptAllocPkg::TERMS_PER
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCL*TPC-1:0]  termsIn,
  input  steerCtl_t           ctl,
  output logic [NCL-1:0]      sumOut
);
  localparam int NBITS = NCL * NWIN;

  logic [NCL-1:0]   clusterHit;
  logic [NBITS-1:0] hitSel;
  logic [NBITS-1:0] claimVec;
  logic [NCL-1:0]   sumNext;

  generate
    for (genvar c = 0; c < NCL; c++) begin : g_clu
      assign clusterHit[c] = |termsIn[c*TPC +: TPC];
      for (genvar k = 0; k < NWIN; k++) begin : g_claim
        localparam int OWN = c + LEAD - k;
        if (OWN >= 0 && OWN < NCL) begin : g_v
          assign claimVec[c*NWIN+k] = ctl.grant[OWN*NWIN+k];
        end else begin : g_n
          assign claimVec[c*NWIN+k] = 1'b0;
        end
      end

      // R8
      one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
        !ctl.overlapNow |-> $onehot0(claimVec[c*NWIN +: NWIN]));
    end

    for (genvar m = 0; m < NCL; m++) begin : g_cell
      for (genvar k = 0; k < NWIN; k++) begin : g_pos
        localparam int CL = m - LEAD + k;
        if (CL >= 0 && CL < NCL) begin : g_in
          assign hitSel[m*NWIN+k] = ctl.grant[m*NWIN+k] & clusterHit[CL];
        end else begin : g_out
          assign hitSel[m*NWIN+k] = 1'b0;
        end
      end
      assign sumNext[m] = |hitSel[m*NWIN +: NWIN];

      // R5
      idle_cell_chk: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.grant[m*NWIN +: NWIN] == '0) |=> !sumOut[m]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumOut <= '0;
    else       sumOut <= sumNext;
  end

  // R4
  quiet_terms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termsIn == '0) |=> (sumOut == '0));
endmodule

// File: rtl/ptClusterSteer.sv
module ptClusterSteer
  import ptAllocPkg::*;
#(
  parameter int TPC = ptAllocPkg::TERMS_PER
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [CLUSTERS*TPC-1:0] termsIn,
  input  logic [CLUSTERS*WIN-1:0] selCfg,
  output logic [CLUSTERS-1:0]    sumOut,
  output logic                   overlapErr,
  output logic                   windowErr
);
  steerCtl_t ctlBus;

  ptSteerCtl #(.NCL(CLUSTERS), .NWIN(WIN), .LEAD(WIN_LEAD)) ctl_i (
    .clk(clk), .rstN(rstN), .selCfg(selCfg), .ctl(ctlBus),
    .overlapErr(overlapErr), .windowErr(windowErr)
  );

  ptSteerDp #(.NCL(CLUSTERS), .NWIN(WIN), .LEAD(WIN_LEAD), .TPC(TPC)) dp_i (
    .clk(clk), .rstN(rstN), .termsIn(termsIn), .ctl(ctlBus), .sumOut(sumOut)
  );
endmodule

// File: tb/ptClusterSteer_tb.sv
`timescale 1ns/1ps
module ptClusterSteer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] termsIn = '0;
  logic [63:0] selCfg = '0;
  logic [15:0] sumOut;
  logic        overlapErr, windowErr;
  int total = 0;
  int bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  ptClusterSteer dut_i (.clk(clk), .rstN(rstN), .termsIn(termsIn), .selCfg(selCfg),
                        .sumOut(sumOut), .overlapErr(overlapErr), .windowErr(windowErr));

  function automatic logic [15:0] expSum(input logic [63:0] t, input logic [63:0] s);
    logic [15:0] r = '0;
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++) begin
        int cl = m - 1 + k;
        if (cl >= 0 && cl < 16 && s[m*4+k] && (t[cl*4 +: 4] != 4'b0)) r[m] = 1'b1;
      end
    return r;
  endfunction

  function automatic logic expOverlap(input logic [63:0] s);
    int cnt[16];
    logic r = 1'b0;
    for (int c = 0; c < 16; c++) cnt[c] = 0;
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++) begin
        int cl = m - 1 + k;
        if (cl >= 0 && cl < 16 && s[m*4+k]) cnt[cl]++;
      end
    for (int c = 0; c < 16; c++) if (cnt[c] > 1) r = 1'b1;
    return r;
  endfunction

  function automatic logic expWindow(input logic [63:0] s);
    logic r = 1'b0;
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++) begin
        int cl = m - 1 + k;
        if ((cl < 0 || cl >= 16) && s[m*4+k]) r = 1'b1;
      end
    return r;
  endfunction

  function automatic logic [31:0] nextRng(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge register, sample at the next falling edge.
  task automatic apply(input logic [63:0] t, input logic [63:0] s, input string tag);
    termsIn = t; selCfg = s;
    @(posedge clk); @(negedge clk);
    chk({tag, " sum"}, sumOut, expSum(t, s));
    chk("R8 overlap", {15'b0, overlapErr}, {15'b0, expOverlap(s)});
    chk("R7 window", {15'b0, windowErr}, {15'b0, expWindow(s)});
  endtask

  initial begin
    #(8ns * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] part;
    termsIn = '1; selCfg = '1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero under reset
    chk("R1 reset sum", sumOut, 16'h0);
    chk("R1 reset flags", {14'b0, overlapErr, windowErr}, 16'h0);
    rstN = 1'b1;
    termsIn = '0; selCfg = '0;
    @(negedge clk);

    // R2 R3 R4 R5: every mask of every cell against single-term stimuli
    for (int m = 0; m < 16; m++)
      for (int mask = 0; mask < 16; mask++)
        for (int c = 0; c < 16; c++)
          apply(64'h1 << (c*4 + (c+m) % 4), 64'(mask) << (m*4), "R2 R3 R4 R5 sweep");

    // R5: all selects empty with every term high
    apply('1, '0, "R5 empty");
    // R9: each cell owns its own cluster (k=1), no errors
    part = '0;
    for (int m = 0; m < 16; m++) part[m*4+1] = 1'b1;
    apply('1, part, "R9 partition");
    chk("R9 clean flags", {14'b0, overlapErr, windowErr}, 16'h0);
    // R6: only stray bits set, sums stay zero, window flag raised
    apply('1, 64'hC000_0000_0000_0001 | (64'h8 << 56), "R6 stray only");
    chk("R6 stray sums", sumOut, 16'h0);
    // R6: partition plus stray bits, sums identical to partition
    apply(64'h5555_5555_5555_5555, part | 64'hC000_0000_0000_0001, "R6 stray mixed");
    chk("R6 mixed sums", sumOut, 16'hFFFF);
    // R8: cells 3 and 4 both claim cluster 4
    apply(64'h1 << 16, (64'h4 << 12) | (64'h2 << 16), "R8 overlap pair");
    chk("R8 overlap set", {15'b0, overlapErr}, 16'h1);
    chk("R8 both fed", sumOut, 16'h0018);
    // R10: cell 5 takes all four clusters, each single term alone sets the output
    for (int b = 16; b < 32; b++) begin
      apply(64'h1 << b, 64'hF << 20, "R10 wide");
      chk("R10 wide out", sumOut, 16'h0020);
    end

    // R4 R7 R8: pseudo-random configurations and terms
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] t, s;
      rng = nextRng(rng); t[31:0] = rng;
      rng = nextRng(rng); t[63:32] = rng;
      rng = nextRng(rng); s[31:0] = rng & nextRng(rng);
      rng = nextRng(rng); s[63:32] = rng & nextRng(rng);
      apply(t & (t >> 1) & (t >> 2), s, "R4 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule